// File: doc/BRIEF.md
# Cascadable Pixel Line Capture Front End

This block is the digital entry stage of a display column driver. A wide parallel bus brings six gray codes of six bits each on every clock edge. The block can complement all 36 bits on the way in, under a per-beat flag, and writes them into the next six-column group of a line buffer. The whole buffer is presented as one flat vector to a later stage, which takes it over at the line strobe.

Several drivers share one data bus and are chained by an active-low enable. The previous chip pulls the enable low to start this chip's fill. Once this chip has taken its pixel quota, it pulls its own enable low to start the next chip. A direction input sets whether the fill runs from the first column to the last or the other way. It also sets which of the two enable pins acts as the input and which acts as the output. The pins are modelled as separate in, out and output-enable signals. After the buffer is full, the block stays idle until a line strobe rearms it.

Top module: `pixel_line_capture`

## Requirements
- R1: After a synchronous reset (rst high at a rising clock edge), both enable pin outputs (link_a_out, link_b_out) read 1 and the fill counter restarts at the first group.
- R2: While armed and waiting, a clock edge with the active enable input high leaves line_buf unchanged.
- R3: With scan_rev=0, the k-th capture edge of a line (k counted from 0) writes lane j (pix_bus[6j+5:6j]) into column 6k+j. Column c occupies line_buf[6c+5:6c].
- R4: When bus_inv is 1 at a capture edge, every stored bit of that beat is the complement of the bus bit. When bus_inv is 0, the bits are stored unchanged.
- R5: With scan_rev=1, the k-th capture edge writes lane j into column NUM_COLS-1-(6k+j).
- R6: With scan_rev=0, link_a_in is the enable input and link_b is the output (link_b_oe=1, link_a_oe=0). With scan_rev=1 the roles swap. The non-driving pin's out value is held at 1.
- R7: The active enable output is 1 until the capture edge that completes HANDOFF_PIX pixels. It reads 0 from that edge on, and stays 0 until a line strobe or reset.
- R8: Once NUM_COLS columns have been written, further clock edges change neither line_buf nor the enable output, whatever the enable input and bus carry.
- R9: A line strobe (line_strobe high at a rising edge) returns the enable output to 1, resets the group counter to the start, and rearms the block to wait for the enable input. It does not alter line_buf.
- R10: A reset in the middle of a fill stops the fill. The next fill starts at the first group only after the enable input is low again, and the reset cycle writes nothing.
- R11: Once the first capture of a line has occurred, the following edges keep capturing one group each, even if the enable input returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 1 | Line transfer strobe, rearms the fill |
| scan_rev | input | 1 | 0: fill from column 0 upward, 1: from the last column down |
| bus_inv | input | 1 | 1: complement this beat's data before storing |
| pix_bus | input | LANES*GRAY_W | Six gray codes, lane j at bits [6j+5:6j] |
| link_a_in | input | 1 | Enable pin A, input value |
| link_b_in | input | 1 | Enable pin B, input value |
| link_a_out | output | 1 | Enable pin A, driven value |
| link_b_out | output | 1 | Enable pin B, driven value |
| link_a_oe | output | 1 | Enable pin A drives when 1 |
| link_b_oe | output | 1 | Enable pin B drives when 1 |
| line_buf | output | NUM_COLS*GRAY_W | Captured line, column c at [6c+5:6c] |

## Verification
The bench builds the block with NUM_COLS=24 and HANDOFF_PIX=18. That gives a four-group line with the enable hand-off after the third beat. Both fill directions, the full-buffer idle state and the hand-off edge are therefore reached within a few cycles each. The enable output can be compared against the beat count on every beat, and a complete line can be checked column by column against a model of the mapping.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;
  typedef enum logic [1:0] {
    FILL_WAIT = 2'd0,
    FILL_RUN  = 2'd1,
    FILL_DONE = 2'd2
  } fill_state_e;
endpackage

// File: rtl/pixcap_lane_invert.sv
module pixcap_lane_invert #(
  parameter int LANES  = 6,
  parameter int GRAY_W = 6
) (
  input  logic                    inv,
  input  logic [LANES*GRAY_W-1:0] lanes_in,
  output logic [LANES*GRAY_W-1:0] lanes_out
);
  // each lane is conditionally complemented on its own
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lanes_out[j*GRAY_W +: GRAY_W] = lanes_in[j*GRAY_W +: GRAY_W] ^ {GRAY_W{inv}};
  end
endmodule

// File: rtl/pixcap_sequencer.sv
module pixcap_sequencer
  import pixcap_pkg::*;
#(
  parameter int GROUPS        = 64,
  parameter int HANDOFF_BEATS = 52,
  parameter int CNT_W         = $clog2(GROUPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_strobe,
  input  logic             scan_rev,
  input  logic             start_n,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_addr,
  output logic             handoff_n
);
  localparam logic [CNT_W-1:0] GROUPS_C  = CNT_W'(GROUPS);
  localparam logic [CNT_W-1:0] LAST_C    = CNT_W'(GROUPS - 1);
  localparam logic [CNT_W-1:0] HANDOFF_C = CNT_W'(HANDOFF_BEATS);

  fill_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx  = cnt_q + 1'b1;
  assign wr_en   = !rst && !line_strobe &&
                   ((state_q == FILL_RUN) || (state_q == FILL_WAIT && !start_n));
  assign wr_addr = scan_rev ? (LAST_C - cnt_q) : cnt_q;

  always_ff @(posedge clk) begin
    if (rst || line_strobe) begin
      state_q   <= FILL_WAIT;
      cnt_q     <= '0;
      handoff_n <= 1'b1;
    end else if (wr_en) begin
      cnt_q   <= cnt_nx;
      state_q <= (cnt_nx == GROUPS_C) ? FILL_DONE : FILL_RUN;
      if (cnt_nx == HANDOFF_C) handoff_n <= 1'b0;
    end
  end

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= GROUPS_C);
  a_r7_handoff_after_quota: assert property (@(posedge clk) disable iff (rst)
    !handoff_n |-> cnt_q >= HANDOFF_C);
  a_r7_handoff_sticky: assert property (@(posedge clk) disable iff (rst)
    (!handoff_n && !line_strobe) |=> !handoff_n);
  a_r9_strobe_rearm: assert property (@(posedge clk) disable iff (rst)
    line_strobe |=> (cnt_q == '0 && handoff_n));
  a_r11_run_continues: assert property (@(posedge clk) disable iff (rst)
    (state_q == FILL_RUN && !line_strobe) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pixcap_link_mux.sv
module pixcap_link_mux (
  input  logic scan_rev,
  input  logic handoff_n,
  input  logic link_a_in,
  input  logic link_b_in,
  output logic start_n,
  output logic link_a_out,
  output logic link_b_out,
  output logic link_a_oe,
  output logic link_b_oe
);
  assign start_n    = scan_rev ? link_b_in : link_a_in;
  assign link_a_oe  = scan_rev;
  assign link_b_oe  = !scan_rev;
  assign link_a_out = scan_rev ? handoff_n : 1'b1;
  assign link_b_out = scan_rev ? 1'b1 : handoff_n;
endmodule

// File: rtl/pixcap_line_store.sv
module pixcap_line_store #(
  parameter int GROUPS = 64,
  parameter int LANES  = 6,
  parameter int GRAY_W = 6,
  parameter int CNT_W  = 7
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [CNT_W-1:0]               wr_addr,
  input  logic                           scan_rev,
  input  logic [LANES*GRAY_W-1:0]        lanes_in,
  output logic [GROUPS*LANES*GRAY_W-1:0] store_q
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && (wr_addr == CNT_W'(g));
    for (genvar p = 0; p < LANES; p++) begin : g_col
      logic [GRAY_W-1:0] cell_q;
      // in reverse fill the lane order inside a group is mirrored
      always_ff @(posedge clk) begin
        if (hit)
          cell_q <= scan_rev ? lanes_in[(LANES-1-p)*GRAY_W +: GRAY_W]
                             : lanes_in[p*GRAY_W +: GRAY_W];
      end
      assign store_q[(g*LANES+p)*GRAY_W +: GRAY_W] = cell_q;
    end
  end
endmodule

// File: rtl/pixel_line_capture.sv
module pixel_line_capture #(
  parameter int NUM_COLS    = 384,
  parameter int LANES       = 6,
  parameter int GRAY_W      = 6,
  parameter int HANDOFF_PIX = 312
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       line_strobe,
  input  logic                       scan_rev,
  input  logic                       bus_inv,
  input  logic [LANES*GRAY_W-1:0]    pix_bus,
  input  logic                       link_a_in,
  input  logic                       link_b_in,
  output logic                       link_a_out,
  output logic                       link_b_out,
  output logic                       link_a_oe,
  output logic                       link_b_oe,
  output logic [NUM_COLS*GRAY_W-1:0] line_buf
);
  localparam int GROUPS        = NUM_COLS / LANES;
  localparam int HANDOFF_BEATS = HANDOFF_PIX / LANES;
  localparam int CNT_W         = $clog2(GROUPS + 1);

  logic [LANES*GRAY_W-1:0] lanes_fix;
  logic                    start_n;
  logic                    handoff_n;
  logic                    wr_en;
  logic [CNT_W-1:0]        wr_addr;

  pixcap_lane_invert #(.LANES(LANES), .GRAY_W(GRAY_W)) u_inv (
    .inv(bus_inv), .lanes_in(pix_bus), .lanes_out(lanes_fix)
  );

  pixcap_link_mux u_link (
    .scan_rev(scan_rev), .handoff_n(handoff_n),
    .link_a_in(link_a_in), .link_b_in(link_b_in), .start_n(start_n),
    .link_a_out(link_a_out), .link_b_out(link_b_out),
    .link_a_oe(link_a_oe), .link_b_oe(link_b_oe)
  );

  pixcap_sequencer #(.GROUPS(GROUPS), .HANDOFF_BEATS(HANDOFF_BEATS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .scan_rev(scan_rev),
    .start_n(start_n), .wr_en(wr_en), .wr_addr(wr_addr), .handoff_n(handoff_n)
  );

  pixcap_line_store #(.GROUPS(GROUPS), .LANES(LANES), .GRAY_W(GRAY_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .scan_rev(scan_rev),
    .lanes_in(lanes_fix), .store_q(line_buf)
  );

  // buffer may only move on an edge where the sequencer granted a write
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(line_buf));
endmodule

// File: tb/test_pixel_line_capture.sv
`timescale 1ns/1ps
module test_pixel_line_capture;
  localparam int NC = 24, LN = 6, GW = 6, HP = 18;
  localparam int BW = NC*GW, DW = LN*GW, HB = HP/LN;

  localparam logic [DW:0] VEC [8] = '{
    {1'b0, 36'h123456789}, {1'b1, 36'hFFFFFFFFF}, {1'b0, 36'h000000000}, {1'b1, 36'hA5A5A5A5A},
    {1'b0, 36'h0F0F0F0F0}, {1'b0, 36'h555555555}, {1'b1, 36'hFEDCBA987}, {1'b0, 36'h3C3C3C3C3}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, line_strobe, scan_rev, bus_inv, link_a_in, link_b_in;
  logic [DW-1:0] pix_bus;
  logic link_a_out, link_b_out, link_a_oe, link_b_oe;
  logic [BW-1:0] line_buf;
  logic [BW-1:0] exp_buf;
  int total = 0, bad = 0, beat = 0;

  pixel_line_capture #(.NUM_COLS(NC), .LANES(LN), .GRAY_W(GW), .HANDOFF_PIX(HP)) i_pixel_line_capture (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .scan_rev(scan_rev), .bus_inv(bus_inv),
    .pix_bus(pix_bus), .link_a_in(link_a_in), .link_b_in(link_b_in),
    .link_a_out(link_a_out), .link_b_out(link_b_out), .link_a_oe(link_a_oe), .link_b_oe(link_b_oe),
    .line_buf(line_buf)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_buf(string req);
    total++;
    if (line_buf !== exp_buf) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, line_buf, exp_buf);
    end
  endtask

  task automatic model_capture(logic rev, logic inv, logic [DW-1:0] d);
    for (int j = 0; j < LN; j++) begin
      int col;
      col = rev ? NC-1-(beat*LN+j) : beat*LN+j;
      exp_buf[col*GW +: GW] = d[j*GW +: GW] ^ {GW{inv}};
    end
    beat++;
  endtask

  task automatic set_start(logic rev, logic v);
    link_a_in = rev ? 1'b1 : v;
    link_b_in = rev ? v : 1'b1;
  endtask

  function automatic logic out_pin(logic rev);
    return rev ? link_a_out : link_b_out;
  endfunction

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; line_strobe = 0; scan_rev = 0; bus_inv = 0; pix_bus = '0;
    link_a_in = 1; link_b_in = 1;
    step(); step();
    rst = 0;
    step();
    chk_bit("R1 a_out", link_a_out, 1'b1);
    chk_bit("R1 b_out", link_b_out, 1'b1);
    chk_bit("R6 fwd b_oe", link_b_oe, 1'b1);
    chk_bit("R6 fwd a_oe", link_a_oe, 1'b0);

    // R2: enable input high, bus active, nothing stored
    exp_buf = line_buf;
    pix_bus = 36'hABCDEF012;
    step(); step(); step();
    chk_buf("R2");

    for (int i = 0; i < 8; i++) begin
      logic rev;
      rev = (i >= 4);
      if (i == 4) begin
        // R8: full buffer ignores further edges
        set_start(1'b0, 1'b0); pix_bus = 36'h987654321; bus_inv = 1;
        step(); step();
        chk_buf("R8 buffer");
        chk_bit("R8 enable out", link_b_out, 1'b0);
        set_start(1'b0, 1'b1);
        scan_rev = 1; line_strobe = 1;
        step();
        line_strobe = 0; beat = 0;
        chk_bit("R9 enable out", link_a_out, 1'b1);
        chk_buf("R9 buffer kept");
        chk_bit("R6 rev a_oe", link_a_oe, 1'b1);
        chk_bit("R6 rev b_oe", link_b_oe, 1'b0);
        chk_bit("R6 idle pin", link_b_out, 1'b1);
      end
      // first beat needs the enable low; later beats run with it high (R11)
      set_start(rev, (i % 4 == 0) ? 1'b0 : 1'b1);
      bus_inv = VEC[i][DW];
      pix_bus = VEC[i][DW-1:0];
      step();
      model_capture(rev, VEC[i][DW], VEC[i][DW-1:0]);
      chk_buf(rev ? "R5 R4 R11 reverse beat" : "R3 R4 R11 forward beat");
      chk_bit("R7 handoff", out_pin(rev), (beat >= HB) ? 1'b0 : 1'b1);
    end

    // R10: reset in the middle of a fill
    scan_rev = 0; set_start(1'b0, 1'b1); line_strobe = 1;
    step();
    line_strobe = 0; beat = 0;
    set_start(1'b0, 1'b0); bus_inv = 0; pix_bus = 36'h111111111;
    step();
    model_capture(1'b0, 1'b0, 36'h111111111);
    chk_buf("R10 first beat");
    set_start(1'b0, 1'b1); pix_bus = 36'h222222222; rst = 1;
    step();
    rst = 0;
    chk_buf("R10 reset cycle writes nothing");
    chk_bit("R10 enable out", link_b_out, 1'b1);
    step(); step();
    chk_buf("R10 waits for enable");
    beat = 0;
    set_start(1'b0, 1'b0); bus_inv = 1; pix_bus = 36'h2C2C2C2C2;
    step();
    model_capture(1'b0, 1'b1, 36'h2C2C2C2C2);
    chk_buf("R10 restart at group 0");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule